// File: doc/BRIEF.md
# Self-Terminating Serial Frame Transmitter

This block drives an asynchronous serial line from a 16-bit data word that software writes. The word holds the data bits and, above them, the stop bits written as ones, so software chooses the frame length and the number of stop bits with each write. The written word waits in a holding register. As soon as the shifter is free, the word moves into the shifter and the holding register reports that it is empty again. The line then sends one low start bit, followed by the word least significant bit first. Each bit lasts one baud interval.

A frame ends after the interval of the highest one bit in the word, because shifting stops once only zeros remain. If another word is already waiting at that point, its start bit follows with no idle gap. The bit interval comes from a divisor that the receiver also uses. A break input forces the line low at any time and leaves the shifter's timing untouched.

Top module: `serial_frame_tx`

## Requirements
- R1: After reset the line `txd_o` is high (idle) and `buf_empty_o` is 1.
- R2: A write (`wr_en_i` high at a clock edge) makes `buf_empty_o` read 0 after that edge.
- R3: When the shifter is idle, a waiting word moves into it on the next clock edge. After that edge `buf_empty_o` is 1 again and the line drives the start bit (0).
- R4: With divisor value N on `baud_div_i`, every bit lasts N+1 clock cycles. After the start bit the word goes out least significant bit first, so bit i of the frame after the start bit is word bit i.
- R5: The frame ends after the interval of the highest one bit of the word. Zeros are shifted in at the top, and the line then returns high and stays high while idle.
- R6: An all-zero word sends only the start bit (N+1 cycles low), then the line goes idle.
- R7: If a word is waiting when a frame ends, its start bit begins in the very next cycle with no idle gap, and `buf_empty_o` returns to 1 at that point.
- R8: While `brk_i` is 1 the line is 0, whether the shifter is idle or sending. The frame timing carries on unchanged underneath, and the bits resume once `brk_i` is released.
- R9: The bit length follows the shared divisor. A divisor of 0 gives one-cycle bits, and different divisors give proportionally longer bits.
- R10: A second write while a word is still waiting replaces that word. Only the last written word is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Write strobe for the data word |
| wr_data_i | input | WORD_W (16) | Data word; stop bits as ones above the data |
| baud_div_i | input | DIV_W (15) | Shared divisor N; each bit lasts N+1 cycles |
| brk_i | input | 1 | Break: force the line low |
| txd_o | output | 1 | Serial line, idles high |
| buf_empty_o | output | 1 | Holding register can take a new word |

## Verification
The bench builds the block with its defaults: a 16-bit word, a 15-bit divisor and an unregistered line output, so the line responds to break in the same cycle. It drives small run-time divisors (0 to 4), which brings every bit boundary into reach within a few cycles. With these settings one run covers frames of a single start bit, full 17-bit frames and back-to-back frames. It samples the line in every cycle of every bit, so a frame one cycle too long or too short is caught.

// File: rtl/serial_frame_tx_pkg.sv
package serial_frame_tx_pkg;
   typedef enum logic [1:0] {
      TX_IDLE  = 2'd0,
      TX_START = 2'd1,
      TX_DATA  = 2'd2
   } tx_state_e;
endpackage

// File: rtl/tx_baud_gen.sv
module tx_baud_gen #(
   parameter int DIV_W = 15
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             restart_i,
   input  logic [DIV_W-1:0] div_i,
   output logic             tick_o
);
   logic [DIV_W-1:0] cnt_q;
   logic             at_zero;

   assign at_zero = (cnt_q == '0);
   assign tick_o  = at_zero && !restart_i;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (restart_i || at_zero) begin
         cnt_q <= div_i;
      end else begin
         cnt_q <= cnt_q - 1'b1;
      end
   end
endmodule

// File: rtl/tx_hold_reg.sv
module tx_hold_reg #(
   parameter int WORD_W = 16
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_en_i,
   input  logic [WORD_W-1:0] wr_data_i,
   input  logic              take_i,
   output logic [WORD_W-1:0] data_o,
   output logic              full_o
);
   logic [WORD_W-1:0] data_q;
   logic              full_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         data_q <= '0;
         full_q <= 1'b0;
      end else begin
         if (wr_en_i) begin
            data_q <= wr_data_i;
         end
         // a write in the same cycle as a take keeps the buffer full
         if (wr_en_i) begin
            full_q <= 1'b1;
         end else if (take_i) begin
            full_q <= 1'b0;
         end
      end
   end

   assign data_o = data_q;
   assign full_o = full_q;
endmodule

// File: rtl/tx_shift_fsm.sv
module tx_shift_fsm
   import serial_frame_tx_pkg::*;
#(
   parameter int WORD_W = 16
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              tick_i,
   input  logic              avail_i,
   input  logic [WORD_W-1:0] load_data_i,
   output logic              take_o,
   output logic              restart_o,
   output logic              line_o,
   output logic              active_o
);
   tx_state_e         state_q;
   logic [WORD_W-1:0] sh_q;
   logic [WORD_W-1:0] sh_next;
   logic              frame_end;

   assign sh_next   = sh_q >> 1;
   assign frame_end = tick_i &&
                      (((state_q == TX_START) && (sh_q == '0)) ||
                       ((state_q == TX_DATA)  && (sh_next == '0)));
   assign take_o    = avail_i && ((state_q == TX_IDLE) || frame_end);
   assign restart_o = (state_q == TX_IDLE);
   assign active_o  = (state_q != TX_IDLE);

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         state_q <= TX_IDLE;
         sh_q    <= '0;
      end else if (take_o) begin
         state_q <= TX_START;
         sh_q    <= load_data_i;
      end else if (frame_end) begin
         state_q <= TX_IDLE;
         sh_q    <= '0;
      end else if (tick_i) begin
         if (state_q == TX_START) begin
            state_q <= TX_DATA;
         end else if (state_q == TX_DATA) begin
            sh_q <= sh_next;
         end
      end
   end

   always_comb begin
      unique case (state_q)
         TX_START: line_o = 1'b0;
         TX_DATA:  line_o = sh_q[0];
         default:  line_o = 1'b1;
      endcase
   end
endmodule

// File: rtl/serial_frame_tx.sv
module serial_frame_tx #(
   parameter int WORD_W  = 16,
   parameter int DIV_W   = 15,
   parameter bit OUT_REG = 1'b0
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_en_i,
   input  logic [WORD_W-1:0] wr_data_i,
   input  logic [DIV_W-1:0]  baud_div_i,
   input  logic              brk_i,
   output logic              txd_o,
   output logic              buf_empty_o
);
   if (WORD_W < 2) begin : g_bad_word
      $error("serial_frame_tx: WORD_W must be at least 2");
   end
   if (DIV_W < 1) begin : g_bad_div
      $error("serial_frame_tx: DIV_W must be at least 1");
   end

   logic              tick;
   logic              restart;
   logic              take;
   logic              hold_full;
   logic [WORD_W-1:0] hold_data;
   logic              line;
   logic              frame_active;
   logic              line_gated;

   tx_baud_gen #(.DIV_W(DIV_W)) baud_i (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .restart_i (restart),
      .div_i     (baud_div_i),
      .tick_o    (tick)
   );

   tx_hold_reg #(.WORD_W(WORD_W)) hold_i (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_en_i   (wr_en_i),
      .wr_data_i (wr_data_i),
      .take_i    (take),
      .data_o    (hold_data),
      .full_o    (hold_full)
   );

   tx_shift_fsm #(.WORD_W(WORD_W)) fsm_i (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .tick_i      (tick),
      .avail_i     (hold_full),
      .load_data_i (hold_data),
      .take_o      (take),
      .restart_o   (restart),
      .line_o      (line),
      .active_o    (frame_active)
   );

   assign line_gated  = line && !brk_i;
   assign buf_empty_o = !hold_full;

   if (OUT_REG) begin : g_out_reg
      logic txd_q;
      always_ff @(posedge clk_i) begin
         if (!rst_ni) begin
            txd_q <= 1'b1;
         end else begin
            txd_q <= line_gated;
         end
      end
      assign txd_o = txd_q;
   end else begin : g_out_comb
      assign txd_o = line_gated;
   end
endmodule

// File: rtl/serial_frame_tx_chk.sv
module serial_frame_tx_chk #(
   parameter bit OUT_REG = 1'b0
) (
   input logic clk_i,
   input logic rst_ni,
   input logic wr_en_i,
   input logic brk_i,
   input logic txd_o,
   input logic buf_empty_o,
   input logic active_i
);
   assert_empty_after_reset_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(rst_ni) |-> buf_empty_o);

   assert_write_fills_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_en_i |=> !buf_empty_o);

   assert_empty_means_loaded_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(buf_empty_o) |-> active_i);

   if (!OUT_REG) begin : g_line_checks
      assert_start_low_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
         ($rose(active_i) && !brk_i) |-> !txd_o);

      assert_idle_high_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (!active_i && !brk_i) |-> txd_o);

      assert_break_low_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
         brk_i |-> !txd_o);
   end
endmodule

bind serial_frame_tx serial_frame_tx_chk #(.OUT_REG(OUT_REG)) chk_i (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .wr_en_i     (wr_en_i),
   .brk_i       (brk_i),
   .txd_o       (txd_o),
   .buf_empty_o (buf_empty_o),
   .active_i    (frame_active)
);

// File: tb/serial_frame_tx_tb.sv
module serial_frame_tx_tb_top;
   logic        clk_i = 1'b0;
   logic        rst_ni;
   logic        wr_en_i;
   logic [15:0] wr_data_i;
   logic [14:0] baud_div_i;
   logic        brk_i;
   logic        txd_o;
   logic        buf_empty_o;

   int tests  = 0;
   int failed = 0;

   always #5 clk_i = ~clk_i;

   serial_frame_tx dut_i (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .wr_en_i     (wr_en_i),
      .wr_data_i   (wr_data_i),
      .baud_div_i  (baud_div_i),
      .brk_i       (brk_i),
      .txd_o       (txd_o),
      .buf_empty_o (buf_empty_o)
   );

   // {divisor, word}
   localparam logic [30:0] VEC [6] = '{
      {15'd3, 16'h0155},
      {15'd2, 16'h01A5},
      {15'd0, 16'h0101},
      {15'd4, 16'h8001},
      {15'd1, 16'h0001},
      {15'd0, 16'h03C0}
   };

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      tests++;
      if (!ok) begin
         failed++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int frame_bits(input logic [15:0] w);
      int n = 1;
      for (int i = 0; i < 16; i++) begin
         if (w[i]) n = i + 2;
      end
      return n;
   endfunction

   task automatic write_word(input logic [15:0] w);
      @(negedge clk_i);
      wr_en_i   = 1'b1;
      wr_data_i = w;
      brk_i     = 1'b0;
      @(negedge clk_i);
      wr_en_i = 1'b0;
      #1;
      chk(buf_empty_o == 1'b0, "R2 flag low after write", int'(buf_empty_o), 0);
   endtask

   // Checks a whole frame, one negedge per cycle, starting just after the transfer edge.
   task automatic run_frame(input int div, input logic [15:0] w, input bit exp_empty0,
                            input int wr_at, input logic [15:0] w1, input bit two,
                            input logic [15:0] w2, input int brk_lo, input int brk_hi,
                            input string req);
      int nb = frame_bits(w);
      for (int b = 0; b < nb; b++) begin
         logic e = (b == 0) ? 1'b0 : w[b-1];
         int   bad = 0;
         int   seen = 0;
         for (int c = 0; c <= div; c++) begin
            int idx = b * (div + 1) + c;
            @(negedge clk_i);
            wr_en_i = 1'b0;
            if (idx == wr_at) begin
               wr_en_i = 1'b1; wr_data_i = w1;
            end
            if (two && idx == wr_at + 1) begin
               wr_en_i = 1'b1; wr_data_i = w2;
            end
            brk_i = (idx >= brk_lo) && (idx < brk_hi);
            #1;
            if (idx == 0) begin
               chk(buf_empty_o == exp_empty0, "R3 flag at frame start",
                   int'(buf_empty_o), int'(exp_empty0));
            end
            if (txd_o != (brk_i ? 1'b0 : e)) begin
               bad++;
               seen = int'(txd_o);
            end
         end
         chk(bad == 0, $sformatf("%s bit %0d of word %h", req, b, w), seen,
             int'(brk_i ? 1'b0 : e));
      end
   endtask

   task automatic check_idle(input string req);
      @(negedge clk_i);
      wr_en_i = 1'b0;
      brk_i   = 1'b0;
      #1;
      chk(txd_o == 1'b1, req, int'(txd_o), 1);
   endtask

   initial begin
      repeat (100000) @(posedge clk_i);
      failed++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", tests, failed);
      $finish;
   end

   initial begin
      rst_ni     = 1'b0;
      wr_en_i    = 1'b0;
      wr_data_i  = '0;
      baud_div_i = 15'd3;
      brk_i      = 1'b0;
      repeat (3) @(posedge clk_i);
      @(negedge clk_i);
      rst_ni = 1'b1;
      @(negedge clk_i);
      #1;
      chk(txd_o == 1'b1, "R1 line idle after reset", int'(txd_o), 1);
      chk(buf_empty_o == 1'b1, "R1 flag set after reset", int'(buf_empty_o), 1);

      // R4 R5 R9: table of frames under several divisors
      for (int i = 0; i < 6; i++) begin
         baud_div_i = VEC[i][30:16];
         write_word(VEC[i][15:0]);
         run_frame(int'(VEC[i][30:16]), VEC[i][15:0], 1'b1, -10, '0, 1'b0, '0,
                   -1, -1, "R4 R9 frame");
         check_idle("R5 idle after last one bit");
      end

      // R6: all-zero word gives only a start bit
      baud_div_i = 15'd2;
      write_word(16'h0000);
      run_frame(2, 16'h0000, 1'b1, -10, '0, 1'b0, '0, -1, -1, "R6 zero word");
      check_idle("R6 idle after start bit");

      // R7: waiting word follows with no gap
      baud_div_i = 15'd1;
      write_word(16'h0103);
      run_frame(1, 16'h0103, 1'b1, 0, 16'h0181, 1'b0, '0, -1, -1, "R7 first frame");
      run_frame(1, 16'h0181, 1'b1, -10, '0, 1'b0, '0, -1, -1, "R7 back-to-back frame");
      check_idle("R7 idle after second frame");

      // R10: second write replaces the waiting word
      write_word(16'h0011);
      run_frame(1, 16'h0011, 1'b1, 1, 16'h01F0, 1'b1, 16'h0122, -1, -1, "R10 first frame");
      run_frame(1, 16'h0122, 1'b1, -10, '0, 1'b0, '0, -1, -1, "R10 replacing word");
      check_idle("R10 idle after replaced word");

      // R8: break at idle and during a frame
      baud_div_i = 15'd3;
      @(negedge clk_i);
      brk_i = 1'b1;
      #1;
      chk(txd_o == 1'b0, "R8 break at idle", int'(txd_o), 0);
      write_word(16'h01AA);
      run_frame(3, 16'h01AA, 1'b1, -10, '0, 1'b0, '0, 2, 9, "R8 break mid-frame");
      check_idle("R8 idle after break frame");

      $display("[TB] %0d tests run, %0d failed", tests, failed);
      $finish;
   end
endmodule